// File: doc/BRIEF.md
# Power-Up Latched Test Mode Selector

This block decides how the reference clock output behaves. The output can run normally. It can be put into high impedance. It can also carry a divided copy of the reference (REF/N) for test. The decision is made once after power-up. A strap level is captured on a strobe, and that level picks which of two control paths governs the output from then on.

- **Strap captured high (hardware path).** A real-time test pin and a select register bit govern the output. Test mode is always active on this path.
- **Strap captured low (register path).** Test mode begins only when software sets an entry bit. After that, the select bit alone picks high impedance or REF/N.

Test mode is one-shot. Once entered, it persists until power is cycled, which the power-on reset models. Electrical detection of the three-level strap is done elsewhere. This block receives a resolved digital level and a capture strobe. All inputs are plain control levels, and no stream interface is involved.

The outputs are a two-bit mode code and an output enable. Both follow the live pin and select inputs combinationally, given the captured state.

Top module: `tmsel_top`

## Requirements
- R1: While `por_n` is low, and at the first clock after its release, the block behaves as follows: `mode_o` is 2'b00 (normal), `ref_oe_o` is 1, the strap is treated as captured low and the entry bit as not taken.
- R2: The strap level is captured at the first rising clock edge after reset at which `sel_strobe_i` is 1. Later strobes are ignored until the next power-on reset. Before the capture, the register path applies.
- R3: When the strap was captured high and `tm_pin_i` is 1, `mode_o` is 2'b10 (REF/N), whatever `cfg_enter_i` and `cfg_refdiv_i` are.
- R4: When the strap was captured high and `tm_pin_i` is 0, `cfg_refdiv_i` selects the mode: 0 gives 2'b01 (high impedance) and 1 gives 2'b10 (REF/N). `cfg_enter_i` has no effect on this path.
- R5: On the register path, the entry bit `cfg_enter_i` is acted on from the rising edge at which it is seen high. From then on, `cfg_refdiv_i` selects the mode: 0 gives 2'b01 and 1 gives 2'b10. `tm_pin_i` is ignored.
- R6: On the register path, before entry, `mode_o` is 2'b00, whatever `tm_pin_i` and `cfg_refdiv_i` are.
- R7: Once taken, the entry bit stays in effect after `cfg_enter_i` returns to 0, until the next power-on reset.
- R8: `ref_oe_o` is 0 exactly when `mode_o` is 2'b01. The code 2'b11 never appears.
- R9: A new power-on reset pulse clears both the captured strap and the entry bit, so a different path can be chosen after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sel_lvl_i | input | 1 | Resolved strap level |
| sel_strobe_i | input | 1 | Strap capture strobe |
| tm_pin_i | input | 1 | Real-time test pin |
| cfg_enter_i | input | 1 | Register bit requesting test entry |
| cfg_refdiv_i | input | 1 | Register bit: 1 selects REF/N, 0 selects high impedance |
| mode_o | output | 2 | Mode code: 00 normal, 01 high impedance, 10 REF/N |
| ref_oe_o | output | 1 | Reference output enable |

## Verification
The bench models the captured strap and the entry state separately from the design. It compares both outputs on every clock.

- **Corrupted captured strap.** Every input pattern then decodes on the wrong path. This shows at the ports in the same cycle, for example normal where high impedance was expected, or the test pin forcing REF/N where it should be ignored.
- **Lost or unwanted entry state.** This appears on the first cycle after the write, or after the bit is cleared.
- **Missed strobe lock.** A strobe arriving after the capture then flips the path, and the bench sees it one edge later.

// File: rtl/tmsel_pkg.sv
package tmsel_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL = 2'b00,
    MODE_HIZ    = 2'b01,
    MODE_REFDIV = 2'b10
  } mode_e;
endpackage

// File: rtl/tmsel_capture.sv
// One-shot latch of the resolved strap level.
module tmsel_capture (
  input  logic clk,
  input  logic por_n,
  input  logic lvl_i,
  input  logic strobe_i,
  output logic hw_path_o
);
  logic lock_q;
  logic hw_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q <= 1'b0;
      hw_q   <= 1'b0;
    end else if (strobe_i && !lock_q) begin
      lock_q <= 1'b1;
      hw_q   <= lvl_i;
    end
  end

  assign hw_path_o = hw_q;

  // R2: after the capture, later strobes leave the path unchanged
  a_r2_capture_frozen: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> $stable(hw_q));
endmodule

// File: rtl/tmsel_entry.sv
// Sticky test-entry flag for the register path.
module tmsel_entry (
  input  logic clk,
  input  logic por_n,
  input  logic hw_path_i,
  input  logic enter_i,
  output logic entered_o
);
  logic entered_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) entered_q <= 1'b0;
    else if (enter_i && !hw_path_i) entered_q <= 1'b1;
  end

  assign entered_o = entered_q;

  // R7: entry never clears without a power-on reset
  a_r7_entry_sticky: assert property (@(posedge clk) disable iff (!por_n)
    entered_q |=> entered_q);
endmodule

// File: rtl/tmsel_decode.sv
// Maps path, entry state and live inputs to the mode code and the enable.
module tmsel_decode
  import tmsel_pkg::*;
(
  input  logic              hw_path_i,
  input  logic              entered_i,
  input  logic              tm_pin_i,
  input  logic              refdiv_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              oe_o
);
  mode_e test_sel;
  mode_e mode;

  always_comb begin
    test_sel = refdiv_i ? MODE_REFDIV : MODE_HIZ;
    if (hw_path_i) mode = tm_pin_i ? MODE_REFDIV : test_sel;
    else if (entered_i) mode = test_sel;
    else mode = MODE_NORMAL;
  end

  assign mode_o = mode;
  assign oe_o   = (mode != MODE_HIZ);
endmodule

// File: rtl/tmsel_top.sv
module tmsel_top
  import tmsel_pkg::*;
(
  input  logic              clk,
  input  logic              por_n,
  input  logic              sel_lvl_i,
  input  logic              sel_strobe_i,
  input  logic              tm_pin_i,
  input  logic              cfg_enter_i,
  input  logic              cfg_refdiv_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              ref_oe_o
);
  logic hw_path;
  logic entered;

  tmsel_capture u_cap (
    .clk      (clk),
    .por_n    (por_n),
    .lvl_i    (sel_lvl_i),
    .strobe_i (sel_strobe_i),
    .hw_path_o(hw_path)
  );

  tmsel_entry u_ent (
    .clk      (clk),
    .por_n    (por_n),
    .hw_path_i(hw_path),
    .enter_i  (cfg_enter_i),
    .entered_o(entered)
  );

  tmsel_decode u_dec (
    .hw_path_i(hw_path),
    .entered_i(entered),
    .tm_pin_i (tm_pin_i),
    .refdiv_i (cfg_refdiv_i),
    .mode_o   (mode_o),
    .oe_o     (ref_oe_o)
  );

  // R3: the pin forces REF/N on the hardware path
  a_r3_pin_forces_refdiv: assert property (@(posedge clk) disable iff (!por_n)
    (hw_path && tm_pin_i) |-> (mode_o == MODE_REFDIV));

  // R4: the hardware path never runs normally
  a_r4_hw_never_normal: assert property (@(posedge clk) disable iff (!por_n)
    hw_path |-> (mode_o != MODE_NORMAL));

  // R6: normal until entry on the register path
  a_r6_normal_before_entry: assert property (@(posedge clk) disable iff (!por_n)
    (!hw_path && !entered) |-> (mode_o == MODE_NORMAL));

  // R8: the enable drops only in high impedance, and 11 is never produced
  a_r8_oe_matches_hiz: assert property (@(posedge clk) disable iff (!por_n)
    (!ref_oe_o) |-> (mode_o == MODE_HIZ));
  a_r8_no_illegal_code: assert property (@(posedge clk) disable iff (!por_n)
    mode_o != 2'b11);
endmodule

// File: tb/tmsel_top_tb_top.sv
`timescale 1ns/1ps
module tmsel_top_tb_top;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic sel_lvl = 1'b0, sel_strobe = 1'b0, tm_pin = 1'b0;
  logic cfg_enter = 1'b0, cfg_refdiv = 1'b0;
  logic [1:0] mode;
  logic oe;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done = 1'b0;

  // reference state
  bit m_lock, m_hw, m_ent;

  always #5 clk = ~clk;

  tmsel_top dut_i (
    .clk(clk), .por_n(por_n), .sel_lvl_i(sel_lvl), .sel_strobe_i(sel_strobe),
    .tm_pin_i(tm_pin), .cfg_enter_i(cfg_enter), .cfg_refdiv_i(cfg_refdiv),
    .mode_o(mode), .ref_oe_o(oe)
  );

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_lock <= 1'b0; m_hw <= 1'b0; m_ent <= 1'b0;
    end else begin
      if (sel_strobe && !m_lock) begin
        m_lock <= 1'b1; m_hw <= sel_lvl;
      end
      if (cfg_enter && !m_hw) m_ent <= 1'b1;
    end
  end

  function automatic int expect_mode();
    if (!por_n) return 0;
    if (m_hw) begin
      if (tm_pin) return 2;
      return cfg_refdiv ? 2 : 1;
    end
    if (m_ent) return cfg_refdiv ? 2 : 1;
    return 0;
  endfunction

  task automatic check_now();
    int em = expect_mode();
    bit eo = (em != 1);
    checks++;
    if (int'(mode) != em || oe != eo) begin
      errors++;
      $display("FAIL %s: mode=%0d oe=%0d expected mode=%0d oe=%0d",
               phase, mode, oe, em, eo);
    end
  endtask

  // at each falling edge: compare, then apply the next inputs
  task automatic step(input bit lvl, input bit stb, input bit tm,
                      input bit en, input bit rd);
    @(negedge clk);
    check_now();
    sel_lvl = lvl; sel_strobe = stb; tm_pin = tm; cfg_enter = en; cfg_refdiv = rd;
  endtask

  task automatic power_cycle();
    @(negedge clk);
    por_n = 1'b0;
    sel_lvl = 0; sel_strobe = 0; tm_pin = 0; cfg_enter = 0; cfg_refdiv = 0;
    repeat (3) begin @(negedge clk); check_now(); end
    por_n = 1'b1;
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    phase = "R1";
    repeat (3) begin @(negedge clk); check_now(); end
    por_n = 1'b1;
    step(0, 0, 0, 0, 0);
    // R6: register path, no entry, pin and select wiggled
    phase = "R6";
    step(0, 0, 1, 0, 1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    // R2: capture low, then a later high strobe must be ignored
    phase = "R2";
    step(0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    step(1, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0);
    // R5: entry, then select picks the mode, pin ignored
    phase = "R5";
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 1, 1, 1);
    step(0, 0, 0, 1, 1);
    // R7: clearing the entry bit has no effect
    phase = "R7";
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1);
    // R9: power cycle clears, then take the hardware path
    phase = "R9";
    power_cycle();
    step(0, 0, 1, 0, 1);
    step(1, 1, 0, 0, 0);
    // R4: pin low, select decides, entry has no effect
    phase = "R4";
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0);
    // R3: pin high forces REF/N
    phase = "R3";
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 1, 0);
    step(0, 0, 1, 1, 1);
    step(0, 1, 0, 0, 0);
    // R2: a low strobe after the high capture is ignored
    phase = "R2";
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    // R8: enable follows the mode across all combinations
    phase = "R8";
    for (int i = 0; i < 8; i++) step(0, 0, i[0], i[1], i[2]);
    phase = "R9";
    power_cycle();
    step(0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0);
    @(negedge clk); check_now();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule